// File: doc/BRIEF.md
# Integer Compare to Condition Field

This block compares an integer operand with a second operand and writes the four-bit outcome into one slot of a 32-bit condition register. The second operand is either a full register value or a 16-bit immediate. A two-bit operation code selects one of four forms. It sets whether the compare is signed or unsigned, and whether the immediate is used.

The outcome has four flags: less-than, greater-than, equal, and a copy of the summary-overflow input. It goes into one of eight fields chosen by a three-bit index, and every other field is left untouched. The condition register is held inside the block, so successive compares build up state across fields. The register is driven straight out for the surrounding pipeline to read.

A width bit selects between a compare over the full datapath and a compare over the low 32 bits. With the default 32-bit datapath both settings behave the same way.

Top module: `cr_compare_unit`

## Requirements
- R1: After reset, `cr_out` is all zeros.
- R2: Operation codes 0 (signed immediate) and 1 (signed register) compare the operands as two's-complement numbers.
- R3: Operation codes 2 (unsigned immediate) and 3 (unsigned register) compare the operands as unsigned numbers.
- R4: In code 0 the 16-bit immediate is sign-extended to the datapath width. In code 2 it is zero-extended. In the immediate forms `opb` is not used.
- R5: A written field holds, from its most to its least significant bit: less-than, greater-than, equal, summary-overflow. Exactly one of the top three bits is set.
- R6: The least significant bit of the written field equals `so_in` as sampled with the compare.
- R7: Field index k occupies `cr_out` bits 31-4k down to 28-4k, so index 0 is bits 31..28 and index 7 is bits 3..0. No other field changes on a compare.
- R8: A compare with `cmp_valid` high shows on `cr_out` after the next rising clock edge. While `cmp_valid` is low, `cr_out` keeps its value whatever the other inputs do.
- R9: With the default 32-bit datapath, `cmp_wide` has no effect on the result. When it is 0, only the low 32 bits of the operands take part.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Perform a compare this cycle |
| cmp_op | input | 2 | 0 signed-imm, 1 signed-reg, 2 unsigned-imm, 3 unsigned-reg |
| cmp_field | input | 3 | Target field index |
| cmp_wide | input | 1 | 1: full-width compare, 0: low 32 bits |
| opa | input | 32 | First operand |
| opb | input | 32 | Register second operand |
| imm | input | 16 | Immediate second operand |
| so_in | input | 1 | Current summary-overflow bit |
| cr_out | output | 32 | Condition register |

## Verification
The properties assume that `rst_n` is asserted for at least one clock edge before any checked cycle. They also assume that `cmp_op`, `cmp_field` and the operands are known values whenever `cmp_valid` is high. They look one cycle back, at the compare that was issued, and relate it to the field it wrote and to every field it must leave alone.

The stimulus drives every input on the falling edge, starting from zeros at time zero. It holds reset for several edges. It then sweeps all four operation codes over a grid of boundary values: zero, one, all ones, the largest positive, the most negative, and the values at the immediate sign boundary. The target field, the width bit and `so_in` rotate from one vector to the next. Cycles with the strobe low are interleaved to confirm that the register holds.

// File: rtl/crcmp_pkg.sv
package crcmp_pkg;

    typedef enum logic [1:0] {
        OP_SIMM = 2'b00,
        OP_SREG = 2'b01,
        OP_UIMM = 2'b10,
        OP_UREG = 2'b11
    } cmp_op_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_field_t;

endpackage

// File: rtl/crcmp_operand_shaper.sv
module crcmp_operand_shaper #(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 32,
    parameter int IMM_W    = 16
) (
    input  logic              is_unsigned,
    input  logic              use_reg,
    input  logic              wide,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] a_eff,
    output logic [DATA_W-1:0] b_eff
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] b_raw;

    always_comb begin
        imm_ext = {{EXT_W{imm[IMM_W-1] & ~is_unsigned}}, imm};
        b_raw   = use_reg ? opb : imm_ext;
    end

    generate
        if (DATA_W > NARROW_W) begin : g_narrowing
            localparam int PAD_W = DATA_W - NARROW_W;
            always_comb begin
                if (wide) begin
                    a_eff = opa;
                    b_eff = b_raw;
                end else begin
                    a_eff = {{PAD_W{opa[NARROW_W-1] & ~is_unsigned}}, opa[NARROW_W-1:0]};
                    b_eff = {{PAD_W{b_raw[NARROW_W-1] & ~is_unsigned}}, b_raw[NARROW_W-1:0]};
                end
            end
        end else begin : g_full
            logic unused_wide;
            assign unused_wide = wide;
            assign a_eff = opa;
            assign b_eff = b_raw;
        end
    endgenerate

endmodule

// File: rtl/crcmp_magnitude.sv
module crcmp_magnitude
    import crcmp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              is_unsigned,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              so,
    output cond_field_t       code
);
    always_comb begin
        if (is_unsigned) begin
            code.lt = a < b;
            code.gt = a > b;
        end else begin
            code.lt = $signed(a) < $signed(b);
            code.gt = $signed(a) > $signed(b);
        end
        code.eq = (a == b);
        code.so = so;
    end
endmodule

// File: rtl/crcmp_field_merge.sv
module crcmp_field_merge #(
    parameter int FIELD_W    = 4,
    parameter int NUM_FIELDS = 8,
    parameter int IDX_W      = $clog2(NUM_FIELDS),
    parameter int CR_W       = FIELD_W * NUM_FIELDS
) (
    input  logic [CR_W-1:0]    cr_in,
    input  logic [IDX_W-1:0]   sel,
    input  logic [FIELD_W-1:0] code,
    output logic [CR_W-1:0]    cr_next
);
    generate
        for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_slot
            localparam int LO = CR_W - (i + 1) * FIELD_W;
            assign cr_next[LO +: FIELD_W] =
                (sel == IDX_W'(i)) ? code : cr_in[LO +: FIELD_W];
        end
    endgenerate
endmodule

// File: rtl/cr_compare_unit.sv
module cr_compare_unit
    import crcmp_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int NARROW_W   = 32,
    parameter int IMM_W      = 16,
    parameter int FIELD_W    = 4,
    parameter int NUM_FIELDS = 8,
    localparam int IDX_W     = $clog2(NUM_FIELDS),
    localparam int CR_W      = FIELD_W * NUM_FIELDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic [1:0]        cmp_op,
    input  logic [IDX_W-1:0]  cmp_field,
    input  logic              cmp_wide,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [IMM_W-1:0]  imm,
    input  logic              so_in,
    output logic [CR_W-1:0]   cr_out
);
    cmp_op_e           op;
    logic              is_unsigned;
    logic              use_reg;
    logic [DATA_W-1:0] a_eff;
    logic [DATA_W-1:0] b_eff;
    cond_field_t       code;
    logic [CR_W-1:0]   cr_q;
    logic [CR_W-1:0]   cr_next;

    always_comb begin
        op = cmp_op_e'(cmp_op);
        unique case (op)
            OP_SIMM: begin is_unsigned = 1'b0; use_reg = 1'b0; end
            OP_SREG: begin is_unsigned = 1'b0; use_reg = 1'b1; end
            OP_UIMM: begin is_unsigned = 1'b1; use_reg = 1'b0; end
            OP_UREG: begin is_unsigned = 1'b1; use_reg = 1'b1; end
            default: begin is_unsigned = 1'b0; use_reg = 1'b0; end
        endcase
    end

    crcmp_operand_shaper #(
        .DATA_W(DATA_W), .NARROW_W(NARROW_W), .IMM_W(IMM_W)
    ) u_shaper (
        .is_unsigned(is_unsigned), .use_reg(use_reg), .wide(cmp_wide),
        .opa(opa), .opb(opb), .imm(imm), .a_eff(a_eff), .b_eff(b_eff)
    );

    crcmp_magnitude #(.DATA_W(DATA_W)) u_mag (
        .is_unsigned(is_unsigned), .a(a_eff), .b(b_eff), .so(so_in), .code(code)
    );

    crcmp_field_merge #(
        .FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS), .IDX_W(IDX_W), .CR_W(CR_W)
    ) u_merge (
        .cr_in(cr_q), .sel(cmp_field), .code(code), .cr_next(cr_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)         cr_q <= '0;
        else if (cmp_valid) cr_q <= cr_next;
    end

    assign cr_out = cr_q;

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> $stable(cr_out));

    generate
        for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_chk
            localparam int LO = CR_W - (i + 1) * FIELD_W;
            // R7
            other_field_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cmp_valid && cmp_field != IDX_W'(i)) |=> $stable(cr_out[LO +: FIELD_W]));
            // R6
            so_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cmp_valid && cmp_field == IDX_W'(i)) |=> (cr_out[LO] == $past(so_in)));
            // R5
            one_relation_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cmp_valid && cmp_field == IDX_W'(i))
                    |=> ($countones(cr_out[LO+1 +: FIELD_W-1]) == 1));
        end
    endgenerate

endmodule

// File: tb/cr_compare_unit_test.sv
module cr_compare_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 1'b0;
    logic [1:0]  cmp_op = 2'd0;
    logic [2:0]  cmp_field = 3'd0;
    logic        cmp_wide = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [15:0] imm = '0;
    logic        so_in = 1'b0;
    logic [31:0] cr_out;

    int vectors = 0;
    int fails   = 0;
    logic [31:0] model_cr = '0;
    logic [31:0] vals [8];

    always #2 clk = ~clk;

    cr_compare_unit uut (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_op(cmp_op),
        .cmp_field(cmp_field), .cmp_wide(cmp_wide), .opa(opa), .opb(opb),
        .imm(imm), .so_in(so_in), .cr_out(cr_out)
    );

    // Reference: R2 R3 R4 R5 R6 computed from the requirements
    function automatic logic [3:0] ref_code(input logic [1:0] op, input logic [31:0] a,
                                            input logic [31:0] b, input logic [15:0] im,
                                            input logic so);
        longint av, bv;
        logic [31:0] bsel;
        if (op[0]) bsel = b;
        else if (op[1]) bsel = {16'h0000, im};
        else bsel = {{16{im[15]}}, im};
        if (op[1]) begin
            av = longint'({32'h0, a});
            bv = longint'({32'h0, bsel});
        end else begin
            av = longint'({{32{a[31]}}, a});
            bv = longint'({{32{bsel[31]}}, bsel});
        end
        return {av < bv, av > bv, av == bv, so};
    endfunction

    task automatic check(input string req, input logic [31:0] exp);
        vectors++;
        if (cr_out !== exp) begin
            fails++;
            $display("FAIL %s: cr_out=%08h expected=%08h", req, cr_out, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [2:0] f, input logic w,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic so);
        string req;
        @(negedge clk);
        cmp_valid = 1'b1; cmp_op = op; cmp_field = f; cmp_wide = w;
        opa = a; opb = b; imm = im; so_in = so;
        // R7 field placement: index f at bits 31-4f .. 28-4f
        model_cr[31 - 4*f -: 4] = ref_code(op, a, b, im, so);
        @(negedge clk);
        cmp_valid = 1'b0;
        case (op)
            2'd0: req = "R2 R4 R7 R8";
            2'd1: req = "R2 R5 R6 R7";
            2'd2: req = "R3 R4 R7 R8";
            default: req = "R3 R5 R6 R9";
        endcase
        check(req, model_cr);
    endtask

    task automatic idle_check(input int seed);
        @(negedge clk);
        cmp_valid = 1'b0;
        cmp_field = 3'(seed); cmp_op = 2'(seed >> 3);
        opa = ~opa; opb = opb ^ 32'h5A5A5A5A; imm = ~imm; so_in = ~so_in;
        @(negedge clk);
        check("R8 idle hold", model_cr);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: cr_out=%08h expected=completion", cr_out);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int n;
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
        vals[2] = 32'hFFFF_FFFF; vals[3] = 32'h7FFF_FFFF;
        vals[4] = 32'h8000_0000; vals[5] = 32'h0000_8000;
        vals[6] = 32'hFFFF_8000; vals[7] = 32'h0000_FFFF;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 reset", 32'h0);
        rst_n = 1'b1;

        // R7: index 0 lands in bits 31..28, index 7 in bits 3..0
        issue(2'd1, 3'd0, 1'b0, 32'd1, 32'd2, 16'h0, 1'b1);
        check("R7 field0 LT+SO", 32'h9000_0000);
        issue(2'd1, 3'd7, 1'b0, 32'd5, 32'd5, 16'h0, 1'b0);
        check("R7 field7 EQ", 32'h9000_0002);
        // R4: 0xFFFF is -1 signed but 65535 unsigned, opb ignored
        issue(2'd0, 3'd3, 1'b0, 32'd0, 32'h0, 16'hFFFF, 1'b0);
        check("R4 sext imm GT", 32'h9004_0002);
        issue(2'd2, 3'd3, 1'b0, 32'd0, 32'hFFFF_FFFF, 16'hFFFF, 1'b0);
        check("R4 zext imm LT", 32'h9008_0002);

        n = 0;
        for (int op = 0; op < 4; op++) begin
            for (int ai = 0; ai < 8; ai++) begin
                for (int bi = 0; bi < 8; bi++) begin
                    // R9: cmp_wide toggles without changing the expected code
                    issue(2'(op), 3'(n), 1'(n >> 1), vals[ai], vals[bi],
                          vals[bi][15:0] ^ 16'(ai), 1'(n >> 2));
                    if (n % 7 == 3) idle_check(n);
                    n++;
                end
            end
        end

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        model_cr = '0;
        check("R1 re-reset", model_cr);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule